// File: doc/BRIEF.md
# Split FIFO Receive Half

This block is the consumer half of a FIFO that is cut in two at a block boundary. The producer half sits in another block and decides when words may be sent. This half holds the storage. Every signal that crosses the boundary is registered on both sides, so no combinational path crosses between the two blocks.

Incoming load strobes and data words are captured in flip-flops and then written into a parameterised register array. A local consumer pulls words through an extract request and sees the head word on a multiplexed output. Each accepted extract is returned to the producer as a registered one-cycle strobe. A local init input clears this half and is echoed, registered, to the producer half so both halves restart together even when their resets release at different times.

The producer's flow control is sized by a full-round-trip argument. The depth has to be at least 6 for streaming without bubbles. If the producer uses an early-warning margin, the depth must grow by twice that margin, so a margin of 2 needs 10 entries.

Top module: `sfr_rx_fifo`

## Requirements
- R1: A word presented on `peer_load`/`peer_word` is registered at the next clock edge. `empty` falls one edge later, unless that word was taken by bypass.
- R2: Stored words leave on `dout` in the order they arrived, and `dout` always shows the oldest stored word.
- R3: An extract request while no word is stored and no registered load is pending is ignored. `peer_take` stays low and the state is unchanged.
- R4: When no word is stored and a registered load is pending, `dout` shows that word. An extract in that cycle consumes it directly, and it is never stored, so `empty` stays high.
- R5: Every accepted extract produces exactly one high cycle on `peer_take`, in the cycle after the edge where it was accepted.
- R6: `init` clears the stored count, the pointers and any pending registered load at the next edge. `peer_clear` is a one-edge-delayed copy of `init`.
- R7: Synchronous active-high `rst` leaves `empty` high and both `peer_take` and `peer_clear` low.
- R8: When all DEPTH entries are stored, a registered load together with an accepted extract both take effect, and the count stays at DEPTH.
- R9: A registered load that arrives while DEPTH words are stored and no extract is accepted is a protocol error. The word is dropped, and the checker flags it.
- R10: Pointers are ceil(log2(DEPTH)) bits wide and wrap from DEPTH-1 to 0, so a DEPTH that is not a power of two works. The default DEPTH is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Local clear, also echoed to the producer half |
| peer_load | input | 1 | Load strobe from the producer half |
| peer_word | input | WIDTH | Data word from the producer half |
| take | input | 1 | Local extract request |
| dout | output | WIDTH | Head word (or bypass word when nothing is stored) |
| empty | output | 1 | No word is stored |
| peer_take | output | 1 | Registered strobe of accepted extracts, to the producer |
| peer_clear | output | 1 | Registered copy of `init`, to the producer |

## Verification
The hardest situation to reach is a completely full array that receives a registered load in the same cycle as an extract. The full array must then overwrite the slot that is being freed, in the correct order.

The bench reaches this in two ways. It streams loads without extracting until the array fills. It also forces an extract in exactly the cycles where a pending load meets a full array. Long pseudorandom runs with varying load and extract densities, plus init pulses in the middle of traffic, drive the pointers through many wraps of the non-power-of-two depth. A queue model predicts every output.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    // Decoded per-cycle operation of the receive half.
    typedef struct packed {
        logic take_ok; // extract accepted
        logic byp;     // pending load handed straight to the consumer
        logic rd;      // head entry retired from the array
        logic wr;      // pending load written into the array
    } sfr_op_t;

    // Smallest depth that streams without bubbles for a given producer margin.
    localparam int unsigned SFR_BASE_DEPTH = 6;

    function automatic int unsigned sfr_min_depth(input int unsigned margin);
        return SFR_BASE_DEPTH + 2 * margin;
    endfunction

    // Pointer advance with wrap at an arbitrary depth.
    function automatic int unsigned sfr_wrap_inc(input int unsigned p, input int unsigned depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/sfr_ingress.sv
module sfr_ingress #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load_in,
    input  logic [WIDTH-1:0] word_in,
    output logic             load_q,
    output logic [WIDTH-1:0] word_q
);
    // Boundary flops: the producer's strobe and word are captured before use.
    always_ff @(posedge clk) begin
        if (clr) begin
            load_q <= 1'b0;
        end else begin
            load_q <= load_in;
        end
    end

    always_ff @(posedge clk) begin
        if (load_in) begin
            word_q <= word_in;
        end
    end
endmodule

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
    import sfr_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          ld_v,
    input  logic          take,
    output sfr_op_t       op,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic [CW-1:0] fill,
    output logic          has_data
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] fill_q;

    always_comb begin
        has_data   = (fill_q != '0);
        op.take_ok = take && (has_data || ld_v);
        op.byp     = take && !has_data && ld_v;
        op.rd      = op.take_ok && has_data;
        op.wr      = ld_v && !op.byp && ((fill_q != FULL_CNT) || op.rd);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            fill_q <= '0;
        end else begin
            if (op.wr) begin
                wptr_q <= PW'(sfr_wrap_inc(32'(wptr_q), 32'(DEPTH)));
            end
            if (op.rd) begin
                rptr_q <= PW'(sfr_wrap_inc(32'(rptr_q), 32'(DEPTH)));
            end
            case ({op.wr, op.rd})
                2'b10:   fill_q <= fill_q + CW'(1);
                2'b01:   fill_q <= fill_q - CW'(1);
                default: fill_q <= fill_q;
            endcase
        end
    end

    assign wptr = wptr_q;
    assign rptr = rptr_q;
    assign fill = fill_q;
endmodule

// File: rtl/sfr_store.sv
module sfr_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 6,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr,
    input  logic [PW-1:0]    wptr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PW-1:0]    rptr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] words [DEPTH];

    // One register per entry, each with its own decoded write enable.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [WIDTH-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (wr && (wptr == PW'(i))) begin
                ent_q <= wdata;
            end
        end
        assign words[i] = ent_q;
    end

    // Output multiplexer over the array.
    assign rdata = words[rptr];
endmodule

// File: rtl/sfr_rx_fifo.sv
module sfr_rx_fifo
    import sfr_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             peer_load,
    input  logic [WIDTH-1:0] peer_word,
    input  logic             take,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             peer_take,
    output logic             peer_clear
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic             clr;
    logic             ld_v;
    logic [WIDTH-1:0] ld_word;
    sfr_op_t          op;
    logic [PW-1:0]    wptr, rptr;
    logic [CW-1:0]    fill;
    logic             has_data;
    logic [WIDTH-1:0] arr_word;

    assign clr = rst || init;

    sfr_ingress #(.WIDTH(WIDTH)) u_ingress (
        .clk     (clk),
        .clr     (clr),
        .load_in (peer_load),
        .word_in (peer_word),
        .load_q  (ld_v),
        .word_q  (ld_word)
    );

    sfr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .clr      (clr),
        .ld_v     (ld_v),
        .take     (take),
        .op       (op),
        .wptr     (wptr),
        .rptr     (rptr),
        .fill     (fill),
        .has_data (has_data)
    );

    sfr_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .wr    (op.wr),
        .wptr  (wptr),
        .wdata (ld_word),
        .rptr  (rptr),
        .rdata (arr_word)
    );

    // With nothing stored, the pending registered word is offered directly.
    assign dout  = has_data ? arr_word : ld_word;
    assign empty = !has_data;

    // Boundary output flops.
    always_ff @(posedge clk) begin
        if (clr) begin
            peer_take <= 1'b0;
        end else begin
            peer_take <= op.take_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            peer_clear <= 1'b0;
        end else begin
            peer_clear <= init;
        end
    end
endmodule

// File: rtl/sfr_rx_fifo_chk.sv
module sfr_rx_fifo_chk #(
    parameter int DEPTH = 6,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          init,
    input logic          take,
    input logic          ld_v,
    input logic [CW-1:0] fill,
    input logic          empty,
    input logic          peer_take,
    input logic          peer_clear
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !(ld_v && (fill == CW'(DEPTH)) && !take && !init)); // R9
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH)); // R8
    AST_IGNORED_TAKE: assert property (@(posedge clk) disable iff (rst)
        (take && empty && !ld_v && !init) |=> !peer_take); // R3
    AST_ACCEPT_ACK: assert property (@(posedge clk) disable iff (rst)
        (take && (!empty || ld_v) && !init) |=> peer_take); // R5
    AST_BYPASS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (take && empty && ld_v && !init) |=> empty); // R4
    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        init |=> (empty && peer_clear && !peer_take)); // R6
    AST_CLEAR_ECHO_LOW: assert property (@(posedge clk) disable iff (rst)
        !init |=> !peer_clear); // R6
endmodule

bind sfr_rx_fifo sfr_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .init       (init),
    .take       (take),
    .ld_v       (ld_v),
    .fill       (fill),
    .empty      (empty),
    .peer_take  (peer_take),
    .peer_clear (peer_clear)
);

// File: tb/tb_sfr_rx_fifo.sv
`timescale 1ns/1ps
module tb_sfr_rx_fifo;
    localparam int W = 8;
    localparam int D = 6;

    logic         clk = 1'b0;
    logic         rst, init, peer_load, take;
    logic [W-1:0] peer_word;
    logic [W-1:0] dout;
    logic         empty, peer_take, peer_clear;

    always #2.5 clk = ~clk;

    sfr_rx_fifo #(.WIDTH(W), .DEPTH(D)) dut (
        .clk(clk), .rst(rst), .init(init), .peer_load(peer_load),
        .peer_word(peer_word), .take(take), .dout(dout), .empty(empty),
        .peer_take(peer_take), .peer_clear(peer_clear)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model
    logic [W-1:0] q[$];
    logic         m_ld;
    logic [W-1:0] m_word;
    logic         e_take, e_clr, req_empty_take;
    logic [W-1:0] seq = 8'h10;
    logic [15:0]  lfsr = 16'hACE1;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        chk("R1 empty", W'(empty), W'(q.size() == 0));
        if (q.size() == D)
            chk("R8 head at full", dout, q[0]);
        else if (q.size() > 0)
            chk("R2,R10 head order", dout, q[0]);
        else if (m_ld)
            chk("R4 bypass word", dout, m_word);
        if (req_empty_take)
            chk("R3 ignored extract", W'(peer_take), W'(e_take));
        else
            chk("R5 extract strobe", W'(peer_take), W'(e_take));
        chk("R6 clear echo", W'(peer_clear), W'(e_clr));
    endtask

    // One cycle: drive at negedge, update model at posedge, check at next negedge.
    task automatic step(input logic ld, input logic tk, input logic ini);
        logic tk_f;
        logic acc;
        tk_f = tk || (m_ld && q.size() == D);   // never let a load meet a full array alone
        seq  = seq + 8'd7;
        peer_load = ld; peer_word = seq; take = tk_f; init = ini;
        @(posedge clk);
        req_empty_take = 1'b0;
        if (ini) begin
            q.delete(); m_ld = 1'b0; e_take = 1'b0; e_clr = 1'b1;
        end else begin
            acc = tk_f && (q.size() > 0 || m_ld);
            req_empty_take = tk_f && !acc;
            e_take = acc;
            if (acc) begin
                if (q.size() > 0) begin
                    void'(q.pop_front());
                    if (m_ld) q.push_back(m_word);
                end
            end else if (m_ld) begin
                q.push_back(m_word);
            end
            m_ld = ld; m_word = seq; e_clr = 1'b0;
        end
        @(negedge clk);
        check_outputs();
    endtask

    initial begin
        rst = 1'b1; init = 1'b0; peer_load = 1'b0; take = 1'b0; peer_word = '0;
        m_ld = 1'b0; m_word = '0; e_take = 1'b0; e_clr = 1'b0; req_empty_take = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset empty", W'(empty), W'(1));
        chk("R7 reset strobe", W'(peer_take), W'(0));
        chk("R7 reset clear", W'(peer_clear), W'(0));
        rst = 1'b0;

        // Fill to full, then hold with forced extracts (R8, R9 kept legal)
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b0);
        // Drain past empty (R3)
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b0);
        // Stream from empty: bypass (R4)
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0);
        // Init in the middle of traffic (R6)
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b0);

        // Pseudorandom sweep over several densities
        for (int ph = 0; ph < 8; ph++) begin
            for (int i = 0; i < 600; i++) begin
                logic ld, tk, ini;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                case (ph % 4)
                    0: begin ld = lfsr[0] | lfsr[1]; tk = lfsr[2] & lfsr[3]; end
                    1: begin ld = lfsr[0] & lfsr[1]; tk = lfsr[2] | lfsr[3]; end
                    2: begin ld = lfsr[0];           tk = lfsr[5];           end
                    default: begin ld = 1'b1;        tk = lfsr[4] | lfsr[7]; end
                endcase
                ini = (lfsr[15:9] == 7'h5A);
                step(ld, tk, ini);
            end
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule